// File: doc/BRIEF.md
# Per-process page translation unit

This block maps a linear address issued by a CPU bus cycle onto a physical address. Translation data lives in a dedicated array that is not part of the addressable memory. The array holds one page table for every process: the current process number forms the upper part of the row index and the page field of the linear address forms the lower part. The selected entry supplies a 12-bit physical frame base. The untranslated offset is appended below that base, and control bits in the entry decide whether the access is allowed.

A second, privileged port reads and writes array entries and the current-process register. Entries are addressed with a super-linear address, which is the process number, the page and an offset joined together. Only the process and page parts select a row. In protected mode this port, and the process register behind it, can only be used by code running from a supervisor page. In real mode anyone may use it, and bus cycles pass straight through without translation. During interrupt service, translation always uses table 0, the kernel's table.

The widths of the process and page fields are parameters. The default (3 process bits, 8 page bits, 2048 rows) keeps the array small. The full configuration uses 5 process bits and 12 page bits, giving a 24-bit linear address. Entry layout: bits [11:0] frame base, bit 12 present, bit 13 supervisor-only, bit 14 writable, bit 15 reserved.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, `phys_valid`, `xlate_fault`, `cfg_rvalid` and `cfg_deny` are low, and the current-process register reads 0.
- R2: A request made with `cpu_prot` low returns, one clock later, `phys_valid` high and `phys_addr` equal to `req_addr` zero-extended. The array entry is not consulted and no fault is raised.
- R3: A request made with `cpu_prot` high reads row {process, req_addr page field}. If the access is allowed, one clock later `phys_addr` = {entry[11:0], req_addr[11:0]} with `phys_valid` high.
- R4: While `cpu_irq` is high, the row is taken from table 0, whatever the current-process register holds.
- R5: In protected mode, an entry with bit 12 (present) clear gives `xlate_fault` high, `phys_valid` low and `phys_addr` 0.
- R6: In protected mode, a write to an entry with bit 14 (writable) clear faults. A read of the same entry translates normally.
- R7: In protected mode, an access with `cpu_super` low to an entry with bit 13 (supervisor) set faults. The same access with `cpu_super` high translates.
- R8: Each request produces exactly one of `phys_valid` or `xlate_fault`, one clock later. Neither is raised without a request.
- R9: Entry access (`cfg_op` 0 = read entry, 1 = write entry) selects row `cfg_addr[SL_W-1:12]` and ignores `cfg_addr[11:0]`. Read data appears on `cfg_rdata` with `cfg_rvalid` one clock later. A written entry is used by a request issued in the next cycle.
- R10: With `cpu_prot` high and `cpu_super` low, any privileged-port operation is refused: `cfg_deny` pulses one clock later, `cfg_rvalid` stays low, and neither the array nor the process register changes. With `cpu_prot` low, every operation is accepted.
- R11: `cfg_op` 3 writes `cfg_wdata[PROC_W-1:0]` to the current-process register. `cfg_op` 2 returns it, zero-extended, on `cfg_rdata` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_prot | input | 1 | 1 = protected mode, 0 = real mode |
| cpu_super | input | 1 | Current code runs from a supervisor page |
| cpu_irq | input | 1 | Interrupt service in progress (use table 0) |
| req_valid | input | 1 | Bus-cycle translation request |
| req_write | input | 1 | Request is a write |
| req_addr | input | LIN_W | Linear address (page field above 12-bit offset) |
| phys_valid | output | 1 | Physical address valid, one clock after request |
| phys_addr | output | PHYS_W | Physical address (24 bits) |
| xlate_fault | output | 1 | Request refused by entry control bits |
| cfg_valid | input | 1 | Privileged-port operation strobe |
| cfg_op | input | 2 | 0 read entry, 1 write entry, 2 read process, 3 write process |
| cfg_addr | input | SL_W | Super-linear entry address |
| cfg_wdata | input | 16 | Entry or process write data |
| cfg_rdata | output | 16 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_deny | output | 1 | Operation refused for lack of privilege |

## Verification
Some properties are checked on every cycle: a request yields exactly one of a valid address or a fault in the next cycle, real-mode requests pass through unchanged, faults appear only in protected mode, and a refused privileged operation pulses the deny strobe and leaves the process register untouched. Other behaviours can only be shown by the directed scenarios, because they depend on what the array holds: the frame value a translation produces, the choice of table 0 during interrupts, the three fault causes, the way the low super-linear bits are ignored, and an entry write being used by the very next request.

// File: rtl/xlate_pkg.sv
// Shared constants and types for the page translation unit.
// Assumes a 16-bit entry with a 12-bit frame field and 12-bit page offset.
package xlate_pkg;
    localparam int FRAME_W     = 12;
    localparam int OFF_W       = 12;
    localparam int ENTRY_W     = 16;
    localparam int BIT_PRESENT = 12;
    localparam int BIT_SUPER   = 13;
    localparam int BIT_WRITE   = 14;

    typedef enum logic [1:0] {
        CFG_ENT_RD  = 2'd0,
        CFG_ENT_WR  = 2'd1,
        CFG_PROC_RD = 2'd2,
        CFG_PROC_WR = 2'd3
    } cfg_op_e;
endpackage

// File: rtl/xlate_table.sv
// Translation array: synchronous RAM with one read-only port for bus-cycle
// translation and one read/write port for privileged entry access.
// Assumes no reset of contents; software fills entries before use.
module xlate_table #(
    parameter int ROW_W  = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              xr_en,
    input  logic [ROW_W-1:0]  xr_row,
    output logic [DATA_W-1:0] xr_data,
    input  logic              cp_en,
    input  logic              cp_we,
    input  logic [ROW_W-1:0]  cp_row,
    input  logic [DATA_W-1:0] cp_wdata,
    output logic [DATA_W-1:0] cp_rdata
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Translation read port: registered read of the selected row.
    always_ff @(posedge clk) begin
        if (xr_en) begin
            xr_data <= mem[xr_row];
        end
    end

    // Privileged port: write the row or register its contents.
    always_ff @(posedge clk) begin
        if (cp_en) begin
            if (cp_we) begin
                mem[cp_row] <= cp_wdata;
            end else begin
                cp_rdata <= mem[cp_row];
            end
        end
    end
endmodule

// File: rtl/xlate_cfg_port.sv
// Privileged access port: decodes entry and process-register operations,
// refuses them in protected mode unless code runs from a supervisor page,
// and holds the current-process register.
// Assumes at most one operation per cycle; read data returns one clock later.
module xlate_cfg_port
    import xlate_pkg::*;
#(
    parameter int PROC_W = 3,
    parameter int ROW_W  = 11,
    parameter int SL_W   = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_prot,
    input  logic               cpu_super,
    input  logic               cfg_valid,
    input  logic [1:0]         cfg_op,
    input  logic [SL_W-1:0]    cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    output logic [ENTRY_W-1:0] cfg_rdata,
    output logic               cfg_rvalid,
    output logic               cfg_deny,
    output logic [PROC_W-1:0]  cur_proc,
    output logic               tbl_en,
    output logic               tbl_we,
    output logic [ROW_W-1:0]   tbl_row,
    output logic [ENTRY_W-1:0] tbl_wdata,
    input  logic [ENTRY_W-1:0] tbl_rdata
);
    cfg_op_e             op;
    logic                allowed;
    logic                go;
    logic                rd_proc_q;
    logic [PROC_W-1:0]   proc_snap_q;
    logic                unused_low;

    // Decode the operation and privilege.
    always_comb begin
        op        = cfg_op_e'(cfg_op);
        allowed   = !cpu_prot || cpu_super;
        go        = cfg_valid && allowed;
        tbl_en    = go && (op == CFG_ENT_RD || op == CFG_ENT_WR);
        tbl_we    = go && (op == CFG_ENT_WR);
        tbl_row   = cfg_addr[SL_W-1:OFF_W];
        tbl_wdata = cfg_wdata;
    end

    assign unused_low = ^{cfg_addr[OFF_W-1:0], cfg_wdata[ENTRY_W-1:PROC_W]};

    // Current-process register, written only by an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_proc <= '0;
        end else if (go && op == CFG_PROC_WR) begin
            cur_proc <= cfg_wdata[PROC_W-1:0];
        end
    end

    // Response strobes and read-source selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid  <= 1'b0;
            cfg_deny    <= 1'b0;
            rd_proc_q   <= 1'b0;
            proc_snap_q <= '0;
        end else begin
            cfg_rvalid  <= go && (op == CFG_ENT_RD || op == CFG_PROC_RD);
            cfg_deny    <= cfg_valid && !allowed;
            rd_proc_q   <= (op == CFG_PROC_RD);
            proc_snap_q <= cur_proc;
        end
    end

    // Return data from the array or the process snapshot.
    always_comb begin
        if (!cfg_rvalid) begin
            cfg_rdata = '0;
        end else if (rd_proc_q) begin
            cfg_rdata = {{(ENTRY_W-PROC_W){1'b0}}, proc_snap_q};
        end else begin
            cfg_rdata = tbl_rdata;
        end
    end
endmodule

// File: rtl/xlate_req_stage.sv
// Request stage: forms the array row from the process number (table 0
// during interrupt service) and the page field, and registers the request
// attributes for the resolve stage one clock later.
module xlate_req_stage
    import xlate_pkg::*;
#(
    parameter int PROC_W = 3,
    parameter int PAGE_W = 8,
    parameter int LIN_W  = 20,
    parameter int ROW_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LIN_W-1:0]  req_addr,
    input  logic              cpu_prot,
    input  logic              cpu_super,
    input  logic              cpu_irq,
    input  logic [PROC_W-1:0] cur_proc,
    output logic              rd_en,
    output logic [ROW_W-1:0]  rd_row,
    output logic              v_q,
    output logic              wr_q,
    output logic              prot_q,
    output logic              super_q,
    output logic [LIN_W-1:0]  lin_q
);
    logic [PROC_W-1:0] tbl_sel;

    // Choose the table and build the row index.
    always_comb begin
        tbl_sel = cpu_irq ? '0 : cur_proc;
        rd_en   = req_valid;
        rd_row  = {tbl_sel, req_addr[LIN_W-1:OFF_W]};
    end

    // Hold request attributes alongside the array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q     <= 1'b0;
            wr_q    <= 1'b0;
            prot_q  <= 1'b0;
            super_q <= 1'b0;
            lin_q   <= '0;
        end else begin
            v_q <= req_valid;
            if (req_valid) begin
                wr_q    <= req_write;
                prot_q  <= cpu_prot;
                super_q <= cpu_super;
                lin_q   <= req_addr;
            end
        end
    end
endmodule

// File: rtl/xlate_resolve.sv
// Resolve stage: checks entry control bits against the registered request
// and composes the physical address, or passes the linear address through
// in real mode. Purely combinational. Assumes PHYS_W >= LIN_W.
module xlate_resolve
    import xlate_pkg::*;
#(
    parameter int LIN_W  = 20,
    parameter int PHYS_W = 24
) (
    input  logic               v_q,
    input  logic               wr_q,
    input  logic               prot_q,
    input  logic               super_q,
    input  logic [LIN_W-1:0]   lin_q,
    input  logic [ENTRY_W-1:0] entry,
    output logic               phys_valid,
    output logic               xlate_fault,
    output logic [PHYS_W-1:0]  phys_addr
);
    logic              deny;
    logic [PHYS_W-1:0] pass_addr;
    logic [PHYS_W-1:0] tran_addr;
    logic              unused_rsv;

    assign unused_rsv = entry[ENTRY_W-1];

    // Zero-extend the linear address for real mode.
    generate
        if (PHYS_W > LIN_W) begin : g_pad
            assign pass_addr = {{(PHYS_W-LIN_W){1'b0}}, lin_q};
        end else begin : g_eq
            assign pass_addr = lin_q[PHYS_W-1:0];
        end
    endgenerate

    // Permission check and address selection.
    always_comb begin
        tran_addr = {entry[FRAME_W-1:0], lin_q[OFF_W-1:0]};
        deny      = !entry[BIT_PRESENT]
                 || (wr_q && !entry[BIT_WRITE])
                 || (!super_q && entry[BIT_SUPER]);
        xlate_fault = v_q && prot_q && deny;
        phys_valid  = v_q && !(prot_q && deny);
        if (!phys_valid) begin
            phys_addr = '0;
        end else if (prot_q) begin
            phys_addr = tran_addr;
        end else begin
            phys_addr = pass_addr;
        end
    end
endmodule

// File: rtl/page_xlate_unit.sv
// Per-process page translation unit (top). Joins the request stage, the
// translation array, the resolve stage and the privileged access port.
// One clock from request to physical address or fault.
module page_xlate_unit
    import xlate_pkg::*;
#(
    parameter int PROC_W = 3,
    parameter int PAGE_W = 8,
    localparam int LIN_W  = PAGE_W + OFF_W,
    localparam int PHYS_W = FRAME_W + OFF_W,
    localparam int ROW_W  = PROC_W + PAGE_W,
    localparam int SL_W   = PROC_W + PAGE_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_prot,
    input  logic               cpu_super,
    input  logic               cpu_irq,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [LIN_W-1:0]   req_addr,
    output logic               phys_valid,
    output logic [PHYS_W-1:0]  phys_addr,
    output logic               xlate_fault,
    input  logic               cfg_valid,
    input  logic [1:0]         cfg_op,
    input  logic [SL_W-1:0]    cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    output logic [ENTRY_W-1:0] cfg_rdata,
    output logic               cfg_rvalid,
    output logic               cfg_deny
);
    logic [PROC_W-1:0]  cur_proc;
    logic               rd_en;
    logic [ROW_W-1:0]   rd_row;
    logic [ENTRY_W-1:0] rd_entry;
    logic               v_q, wr_q, prot_q, super_q;
    logic [LIN_W-1:0]   lin_q;
    logic               tbl_en, tbl_we;
    logic [ROW_W-1:0]   tbl_row;
    logic [ENTRY_W-1:0] tbl_wdata, tbl_rdata;

    xlate_req_stage #(
        .PROC_W(PROC_W), .PAGE_W(PAGE_W), .LIN_W(LIN_W), .ROW_W(ROW_W)
    ) u_req (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .cpu_prot(cpu_prot), .cpu_super(cpu_super), .cpu_irq(cpu_irq),
        .cur_proc(cur_proc),
        .rd_en(rd_en), .rd_row(rd_row),
        .v_q(v_q), .wr_q(wr_q), .prot_q(prot_q), .super_q(super_q),
        .lin_q(lin_q)
    );

    xlate_table #(.ROW_W(ROW_W), .DATA_W(ENTRY_W)) u_tbl (
        .clk(clk),
        .xr_en(rd_en), .xr_row(rd_row), .xr_data(rd_entry),
        .cp_en(tbl_en), .cp_we(tbl_we), .cp_row(tbl_row),
        .cp_wdata(tbl_wdata), .cp_rdata(tbl_rdata)
    );

    xlate_resolve #(.LIN_W(LIN_W), .PHYS_W(PHYS_W)) u_res (
        .v_q(v_q), .wr_q(wr_q), .prot_q(prot_q), .super_q(super_q),
        .lin_q(lin_q), .entry(rd_entry),
        .phys_valid(phys_valid), .xlate_fault(xlate_fault),
        .phys_addr(phys_addr)
    );

    xlate_cfg_port #(.PROC_W(PROC_W), .ROW_W(ROW_W), .SL_W(SL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cpu_prot(cpu_prot), .cpu_super(cpu_super),
        .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .cfg_deny(cfg_deny),
        .cur_proc(cur_proc),
        .tbl_en(tbl_en), .tbl_we(tbl_we), .tbl_row(tbl_row),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
    );
endmodule

// File: rtl/xlate_sva.sv
// Checker for the page translation unit, bound to the top module.
module xlate_sva #(
    parameter int LIN_W  = 20,
    parameter int PHYS_W = 24,
    parameter int PROC_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_prot,
    input logic              cpu_super,
    input logic              req_valid,
    input logic [LIN_W-1:0]  req_addr,
    input logic              phys_valid,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              xlate_fault,
    input logic              cfg_valid,
    input logic              cfg_rvalid,
    input logic              cfg_deny,
    input logic [PROC_W-1:0] cur_proc
);
    // R8: never both a valid address and a fault
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(phys_valid && xlate_fault));

    // R8: every request answers in the next cycle
    a_r8_answers: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (phys_valid || xlate_fault));

    // R8: no answer without a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_valid || xlate_fault) |-> $past(req_valid));

    // R2: real mode passes the linear address through
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cpu_prot) |=>
            (phys_valid && phys_addr[LIN_W-1:0] == $past(req_addr)
             && (phys_addr >> LIN_W) == '0));

    // R5: faults arise only from protected-mode requests
    a_r5_fault_prot_only: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_fault |-> $past(cpu_prot));

    // R10: refused operation pulses deny and returns no data
    a_r10_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cpu_prot && !cpu_super) |=> (cfg_deny && !cfg_rvalid));

    // R10: refused operation leaves the process register unchanged
    a_r10_proc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cpu_prot && !cpu_super) |=> $stable(cur_proc));

    // R10: no deny in real mode
    a_r10_real_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cpu_prot) |=> !cfg_deny);
endmodule

bind page_xlate_unit xlate_sva #(
    .LIN_W(LIN_W), .PHYS_W(PHYS_W), .PROC_W(PROC_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .cpu_prot(cpu_prot), .cpu_super(cpu_super),
    .req_valid(req_valid), .req_addr(req_addr),
    .phys_valid(phys_valid), .phys_addr(phys_addr), .xlate_fault(xlate_fault),
    .cfg_valid(cfg_valid), .cfg_rvalid(cfg_rvalid), .cfg_deny(cfg_deny),
    .cur_proc(cur_proc)
);

// File: tb/tb_page_xlate_unit.sv
// Directed bench for the page translation unit. Inputs change at the
// falling edge; outputs are sampled at the next falling edge.
module tb_page_xlate_unit;
    localparam int PROC_W = 3;
    localparam int PAGE_W = 8;
    localparam int LIN_W  = PAGE_W + 12;
    localparam int PHYS_W = 24;
    localparam int SL_W   = PROC_W + PAGE_W + 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_prot = 1'b0, cpu_super = 1'b0, cpu_irq = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [LIN_W-1:0]  req_addr = '0;
    logic              phys_valid, xlate_fault;
    logic [PHYS_W-1:0] phys_addr;
    logic              cfg_valid = 1'b0;
    logic [1:0]        cfg_op = 2'd0;
    logic [SL_W-1:0]   cfg_addr = '0;
    logic [15:0]       cfg_wdata = '0;
    logic [15:0]       cfg_rdata;
    logic              cfg_rvalid, cfg_deny;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    page_xlate_unit #(.PROC_W(PROC_W), .PAGE_W(PAGE_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_prot(cpu_prot), .cpu_super(cpu_super), .cpu_irq(cpu_irq),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .phys_valid(phys_valid), .phys_addr(phys_addr), .xlate_fault(xlate_fault),
        .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .cfg_deny(cfg_deny)
    );

    always #5 clk = ~clk;

    task automatic check(input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_entry(input logic [11:0] frame,
            input bit pres, input bit sup, input bit wr);
        return {1'b0, wr, sup, pres, frame};
    endfunction

    function automatic logic [SL_W-1:0] sl(input logic [PROC_W-1:0] p,
            input logic [PAGE_W-1:0] pg, input logic [11:0] lo);
        return {p, pg, lo};
    endfunction

    // One privileged operation; called at a falling edge, returns at the next.
    task automatic do_cfg(input logic [1:0] op, input logic [SL_W-1:0] a,
                          input logic [15:0] d);
        cfg_valid = 1'b1; cfg_op = op; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // One translation request; same timing as do_cfg.
    task automatic do_req(input logic [LIN_W-1:0] a, input bit wr);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic put_entry(input logic [PROC_W-1:0] p,
            input logic [PAGE_W-1:0] pg, input logic [15:0] e);
        logic sp;
        sp = cpu_prot;
        cpu_prot = 1'b0;
        do_cfg(2'd1, sl(p, pg, 12'h5A5), e);
        cpu_prot = sp;
    endtask

    task automatic set_proc(input logic [PROC_W-1:0] p);
        logic sp;
        sp = cpu_prot;
        cpu_prot = 1'b0;
        do_cfg(2'd3, '0, {{(16-PROC_W){1'b0}}, p});
        cpu_prot = sp;
    endtask

    task automatic t_reset;
        check("R1 phys_valid", {31'd0, phys_valid}, 32'd0);
        check("R1 xlate_fault", {31'd0, xlate_fault}, 32'd0);
        check("R1 cfg_rvalid", {31'd0, cfg_rvalid}, 32'd0);
        check("R1 cfg_deny", {31'd0, cfg_deny}, 32'd0);
        cpu_prot = 1'b0;
        do_cfg(2'd2, '0, '0);
        check("R1 process reg after reset", {15'd0, cfg_rvalid, cfg_rdata}, 32'h0001_0000);
    endtask

    task automatic t_proc_reg;
        set_proc(3'd5);
        do_cfg(2'd2, '0, '0);
        check("R11 process readback", {15'd0, cfg_rvalid, cfg_rdata}, 32'h0001_0005);
    endtask

    task automatic t_entry_access;
        // R9: write with one low field, read with another
        cpu_prot = 1'b0;
        do_cfg(2'd1, sl(3'd5, 8'h3A, 12'hABC), mk_entry(12'h7C1, 1, 0, 1));
        do_cfg(2'd0, sl(3'd5, 8'h3A, 12'h123), '0);
        check("R9 entry read ignores low bits", {15'd0, cfg_rvalid, cfg_rdata},
              {15'd0, 1'b1, mk_entry(12'h7C1, 1, 0, 1)});
    endtask

    task automatic t_translate;
        put_entry(3'd2, 8'h3A, mk_entry(12'h456, 1, 0, 1));
        cpu_prot = 1'b1; cpu_super = 1'b0;
        do_req({8'h3A, 12'h123}, 1'b0);
        check("R3 proc5 translation", {7'd0, phys_valid, phys_addr}, {7'd0, 1'b1, 24'h7C1123});
        check("R8 no fault on success", {31'd0, xlate_fault}, 32'd0);
        @(negedge clk);
        check("R8 idle gives nothing", {30'd0, phys_valid, xlate_fault}, 32'd0);
        set_proc(3'd2);
        do_req({8'h3A, 12'hFED}, 1'b1);
        check("R3 proc2 table differs", {7'd0, phys_valid, phys_addr}, {7'd0, 1'b1, 24'h456FED});
        set_proc(3'd5);
    endtask

    task automatic t_real;
        cpu_prot = 1'b0;
        do_req({8'hC7, 12'hFFF}, 1'b1);
        check("R2 real passthrough", {7'd0, phys_valid, phys_addr}, {7'd0, 1'b1, 24'h0C7FFF});
        check("R2 real no fault", {31'd0, xlate_fault}, 32'd0);
    endtask

    task automatic t_irq;
        put_entry(3'd0, 8'h3A, mk_entry(12'h111, 1, 1, 1));
        cpu_prot = 1'b1; cpu_super = 1'b1; cpu_irq = 1'b1;
        do_req({8'h3A, 12'h042}, 1'b0);
        check("R4 interrupt uses table 0", {7'd0, phys_valid, phys_addr}, {7'd0, 1'b1, 24'h111042});
        cpu_irq = 1'b0;
        do_req({8'h3A, 12'h042}, 1'b0);
        check("R4 back to process table", {7'd0, phys_valid, phys_addr}, {7'd0, 1'b1, 24'h7C1042});
    endtask

    task automatic t_faults;
        put_entry(3'd5, 8'h10, mk_entry(12'h222, 0, 0, 1));
        put_entry(3'd5, 8'h11, mk_entry(12'h333, 1, 0, 0));
        put_entry(3'd5, 8'h12, mk_entry(12'h444, 1, 1, 1));
        cpu_prot = 1'b1; cpu_super = 1'b0;
        do_req({8'h10, 12'h001}, 1'b0);
        check("R5 not present faults", {6'd0, xlate_fault, phys_valid, phys_addr}, {6'd0, 2'b10, 24'h0});
        do_req({8'h11, 12'h002}, 1'b1);
        check("R6 write read-only faults", {30'd0, xlate_fault, phys_valid}, 32'd2);
        do_req({8'h11, 12'h002}, 1'b0);
        check("R6 read read-only ok", {7'd0, phys_valid, phys_addr}, {7'd0, 1'b1, 24'h333002});
        do_req({8'h12, 12'h003}, 1'b0);
        check("R7 user to supervisor faults", {30'd0, xlate_fault, phys_valid}, 32'd2);
        cpu_super = 1'b1;
        do_req({8'h12, 12'h003}, 1'b0);
        check("R7 supervisor access ok", {7'd0, phys_valid, phys_addr}, {7'd0, 1'b1, 24'h444003});
    endtask

    task automatic t_write_then_use;
        // R9: entry written in one cycle drives the request in the next
        cpu_prot = 1'b0;
        do_cfg(2'd1, sl(3'd5, 8'h3A, 12'h000), mk_entry(12'h9AB, 1, 0, 1));
        cpu_prot = 1'b1; cpu_super = 1'b0;
        do_req({8'h3A, 12'h777}, 1'b0);
        check("R9 write used by next request", {7'd0, phys_valid, phys_addr}, {7'd0, 1'b1, 24'h9AB777});
    endtask

    task automatic t_gate;
        cpu_prot = 1'b1; cpu_super = 1'b0;
        do_cfg(2'd1, sl(3'd5, 8'h3A, 12'h0), mk_entry(12'hBAD, 1, 0, 1));
        check("R10 entry write denied", {30'd0, cfg_deny, cfg_rvalid}, 32'd2);
        do_cfg(2'd3, '0, 16'h0001);
        check("R10 process write denied", {31'd0, cfg_deny}, 32'd1);
        do_cfg(2'd0, sl(3'd5, 8'h3A, 12'h0), '0);
        check("R10 entry read denied", {30'd0, cfg_deny, cfg_rvalid}, 32'd2);
        cpu_prot = 1'b0;
        do_cfg(2'd0, sl(3'd5, 8'h3A, 12'h0), '0);
        check("R10 entry unchanged, real mode open", {14'd0, cfg_deny, cfg_rvalid, cfg_rdata},
              {14'd0, 2'b01, mk_entry(12'h9AB, 1, 0, 1)});
        do_cfg(2'd2, '0, '0);
        check("R10 process unchanged", {16'd0, cfg_rdata}, 32'd5);
        cpu_prot = 1'b1; cpu_super = 1'b1;
        do_cfg(2'd2, '0, '0);
        check("R10 supervisor allowed", {14'd0, cfg_deny, cfg_rvalid, cfg_rdata}, 32'h0001_0005);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_proc_reg();
        t_entry_access();
        t_translate();
        t_real();
        t_irq();
        t_faults();
        t_write_then_use();
        t_gate();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule